// File: doc/BRIEF.md
# Up-Counting Raster Line Interrupt Counter

This block raises a CPU interrupt after a programmed number of rendered lines in a cartridge bank controller. It watches two video-side address lines, A12 and A13, only at the moment the video read strobe falls. Each time A12 drops from high to low while A13 is low, it counts one line. That transition only occurs while the pattern tables at $0000-$1FFF are being fetched. The counter counts upward from a value the CPU loads. When it passes its top value it sets a sticky pending flag. That flag drives an active-low interrupt line whenever interrupts are enabled.

Software writes a start value, asks for a reload, and enables the interrupt. Because the counter runs upward, a start value of V gives 256 - V counted lines before the interrupt. A parameter selects between two firing behaviours. In the first, the flag is set on the event that finds the counter at 255. In the second, the flag is set a fixed number of CPU clocks after the counter wraps from 255 to 0. All video inputs are treated as synchronous to the CPU clock.

Top module: `scan_irq_counter`

## Requirements
- R1: After reset the counter, start value, enable and pending flag are all zero, and irq_n is high. With no load, the first interrupt follows 256 counted lines.
- R2: Video inputs are sampled only in a clock cycle where vid_rd_n is low and was high in the previous cycle. A12 changes while the strobe is held high or held low are not seen.
- R3: A line is counted when the sampled A13 is 0, the sampled A12 is 0 and the A12 sampled at the previous strobe fall was 1. The remembered A12 is updated at every strobe fall, including falls with A13 = 1.
- R4: Each counted line adds one to the 8-bit counter, and 255 wraps to 0. A start value of 255 fires on the very first counted line.
- R5: In terminal mode (FIRE_MODE = FIRE_TERMINAL), a line counted while the counter holds 255 sets the pending flag at that same clock. A start value V therefore fires on the (256 - V)th line after the reload.
- R6: In wrap mode (FIRE_MODE = FIRE_WRAP), the pending flag is set WRAP_DELAY clocks after the clock at which the counter wraps from 255 to 0.
- R7: A write with cpu_wr = 1 selects a register through cpu_addr. Value 0 stores cpu_wdata as the start value, 1 requests a reload, 2 enables the interrupt and 3 disables it.
- R8: The start value is copied into the counter one clock after the reload write. A line event that falls on that clock is dropped.
- R9: irq_n is low exactly while the pending flag and the enable bit are both set, with no register delay after either one changes.
- R10: A reload write clears the pending flag at its own clock, and the clear wins over a simultaneous set. Disabling and re-enabling the interrupt leaves the pending flag as it was.
- R11: No minimum spacing between line events applies. Back-to-back events at the fastest strobe rate are each counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_rd_n | input | 1 | Video read strobe, active low |
| vid_a12 | input | 1 | Video address bit 12 |
| vid_a13 | input | 1 | Video address bit 13 |
| cpu_wr | input | 1 | Register write strobe for this block's address range |
| cpu_addr | input | 2 | Register select (0 start value, 1 reload, 2 enable, 3 disable) |
| cpu_wdata | input | 8 | CPU write data |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds two copies of the block side by side: one with FIRE_MODE = FIRE_TERMINAL and one with FIRE_MODE = FIRE_WRAP, both with WRAP_DELAY = 6 and both fed the same stimulus. The terminal copy lets the bench check the exact line on which each start value fires, including 0, 252, 254 and 255. The wrap copy lets it check the clock-exact delay after a wrap, at one clock before and at the expected clock. Sharing the stimulus makes the two firing points directly comparable.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

    typedef enum logic {
        FIRE_TERMINAL = 1'b0,
        FIRE_WRAP     = 1'b1
    } fire_mode_e;

    typedef enum logic [1:0] {
        REG_START   = 2'd0,
        REG_RELOAD  = 2'd1,
        REG_IRQ_ON  = 2'd2,
        REG_IRQ_OFF = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic fall;
        logic a12;
        logic a13;
    } vid_sample_t;

    function automatic logic is_line_edge(input logic prev_a12,
                                          input logic a12,
                                          input logic a13);
        return prev_a12 & ~a12 & ~a13;
    endfunction

endpackage

// File: rtl/scan_irq_edge.sv
module scan_irq_edge
    import scan_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic vid_rd_n,
    input  logic vid_a12,
    input  logic vid_a13,
    output logic line_evt
);

    logic        rd_prev_q;
    logic        a12_prev_q;
    vid_sample_t smp;

    always_comb begin
        smp.fall = rd_prev_q & ~vid_rd_n;
        smp.a12  = vid_a12;
        smp.a13  = vid_a13;
        line_evt = smp.fall & is_line_edge(a12_prev_q, smp.a12, smp.a13);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_prev_q  <= 1'b1;
            a12_prev_q <= 1'b0;
        end else begin
            rd_prev_q <= vid_rd_n;
            if (smp.fall) begin
                a12_prev_q <= smp.a12;
            end
        end
    end

    // R2
    evt_needs_strobe_low_chk: assert property (@(posedge clk) disable iff (rst)
        line_evt |-> (!vid_rd_n && !vid_a12 && !vid_a13));

endmodule

// File: rtl/scan_irq_regs.sv
module scan_irq_regs
    import scan_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_wr,
    input  logic [1:0]       cpu_addr,
    input  logic [CNT_W-1:0] cpu_wdata,
    output logic [CNT_W-1:0] start_q,
    output logic             irq_en_q,
    output logic             pend_clear,
    output logic             reload_q
);

    reg_sel_e sel;

    always_comb begin
        sel        = reg_sel_e'(cpu_addr);
        pend_clear = cpu_wr && (sel == REG_RELOAD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q  <= '0;
            irq_en_q <= 1'b0;
            reload_q <= 1'b0;
        end else begin
            reload_q <= pend_clear;
            if (cpu_wr) begin
                unique case (sel)
                    REG_START:   start_q  <= cpu_wdata;
                    REG_IRQ_ON:  irq_en_q <= 1'b1;
                    REG_IRQ_OFF: irq_en_q <= 1'b0;
                    default:     ;
                endcase
            end
        end
    end

    // R7
    enable_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == 2'd2) |=> irq_en_q);

    // R7
    disable_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == 2'd3) |=> !irq_en_q);

endmodule

// File: rtl/scan_irq_core.sv
module scan_irq_core
    import scan_irq_pkg::*;
#(
    parameter int         CNT_W      = 8,
    parameter fire_mode_e FIRE_MODE  = FIRE_TERMINAL,
    parameter int         WRAP_DELAY = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_evt,
    input  logic             reload_q,
    input  logic             pend_clear,
    input  logic [CNT_W-1:0] start_q,
    output logic             pend_q
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             step;
    logic             wrap_now;

    always_comb begin
        step     = line_evt & ~reload_q;
        wrap_now = step & (cnt_q == CNT_TOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (reload_q) begin
            cnt_q <= start_q;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (FIRE_MODE == FIRE_TERMINAL) begin : g_terminal
            always_ff @(posedge clk) begin
                if (rst || pend_clear) begin
                    pend_q <= 1'b0;
                end else if (wrap_now) begin
                    pend_q <= 1'b1;
                end
            end

            // R5
            terminal_source_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(pend_q) |-> $past(line_evt && !reload_q && cnt_q == CNT_TOP));
        end else begin : g_wrap
            localparam int DLY_W = $clog2(WRAP_DELAY + 1);
            logic [DLY_W-1:0] dly_q;

            always_ff @(posedge clk) begin
                if (rst || pend_clear) begin
                    pend_q <= 1'b0;
                    dly_q  <= '0;
                end else begin
                    if (wrap_now) begin
                        dly_q <= DLY_W'(WRAP_DELAY);
                    end else if (dly_q != '0) begin
                        dly_q <= dly_q - 1'b1;
                    end
                    if (dly_q == DLY_W'(1)) begin
                        pend_q <= 1'b1;
                    end
                end
            end

            // R6
            wrap_source_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(pend_q) |-> ($past(dly_q) == DLY_W'(1)));
        end
    endgenerate

    // R8
    reload_copy_chk: assert property (@(posedge clk) disable iff (rst)
        reload_q |=> (cnt_q == $past(start_q)));

    // R4
    step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        (line_evt && !reload_q) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        pend_clear |=> !pend_q);

    // R10
    pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !pend_clear) |=> pend_q);

endmodule

// File: rtl/scan_irq_counter.sv
module scan_irq_counter
    import scan_irq_pkg::*;
#(
    parameter int         CNT_W      = 8,
    parameter fire_mode_e FIRE_MODE  = FIRE_TERMINAL,
    parameter int         WRAP_DELAY = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vid_rd_n,
    input  logic             vid_a12,
    input  logic             vid_a13,
    input  logic             cpu_wr,
    input  logic [1:0]       cpu_addr,
    input  logic [CNT_W-1:0] cpu_wdata,
    output logic             irq_n
);

    logic             line_evt;
    logic [CNT_W-1:0] start_q;
    logic             irq_en_q;
    logic             pend_clear;
    logic             reload_q;
    logic             pend_q;

    scan_irq_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .vid_rd_n (vid_rd_n),
        .vid_a12  (vid_a12),
        .vid_a13  (vid_a13),
        .line_evt (line_evt)
    );

    scan_irq_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cpu_wr     (cpu_wr),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .start_q    (start_q),
        .irq_en_q   (irq_en_q),
        .pend_clear (pend_clear),
        .reload_q   (reload_q)
    );

    scan_irq_core #(
        .CNT_W      (CNT_W),
        .FIRE_MODE  (FIRE_MODE),
        .WRAP_DELAY (WRAP_DELAY)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .line_evt   (line_evt),
        .reload_q   (reload_q),
        .pend_clear (pend_clear),
        .start_q    (start_q),
        .pend_q     (pend_q)
    );

    assign irq_n = ~(pend_q & irq_en_q);

    // R10
    disable_keeps_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == 2'd3 && pend_q) |=> pend_q);

endmodule

// File: tb/scan_irq_counter_tb_top.sv
`timescale 1ns/1ps
module scan_irq_counter_tb_top;
    import scan_irq_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vid_rd_n = 1'b1;
    logic       vid_a12 = 1'b0;
    logic       vid_a13 = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic       irq_n_t;
    logic       irq_n_w;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    scan_irq_counter #(.CNT_W(8), .FIRE_MODE(FIRE_TERMINAL), .WRAP_DELAY(6)) dut_i (
        .clk(clk), .rst(rst), .vid_rd_n(vid_rd_n), .vid_a12(vid_a12), .vid_a13(vid_a13),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .irq_n(irq_n_t));

    scan_irq_counter #(.CNT_W(8), .FIRE_MODE(FIRE_WRAP), .WRAP_DELAY(6)) dut_wrap_i (
        .clk(clk), .rst(rst), .vid_rd_n(vid_rd_n), .vid_a12(vid_a12), .vid_a13(vid_a13),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .irq_n(irq_n_w));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: irq_n=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic vid_read(input logic a12, input logic a13);
        @(negedge clk);
        vid_a12 = a12; vid_a13 = a13; vid_rd_n = 1'b0;
        @(negedge clk);
        vid_rd_n = 1'b1;
    endtask

    task automatic one_line();
        vid_read(1'b1, 1'b0);
        vid_read(1'b0, 1'b0);
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic arm(input logic [7:0] v);
        cpu_write(2'd0, v);
        cpu_write(2'd1, 8'h00);
        wait_neg(1);
    endtask

    // R1 R5 R6 R9 R10
    task automatic t_reset_and_flags();
        chk("R1 reset terminal", irq_n_t, 1'b1);
        chk("R1 reset wrap", irq_n_w, 1'b1);
        cpu_write(2'd2, 8'h00);
        for (int i = 0; i < 255; i++) one_line();
        chk("R1 255 lines from reset", irq_n_t, 1'b1);
        one_line();
        chk("R5 256th line from reset", irq_n_t, 1'b0);
        wait_neg(5);
        chk("R6 wrap one clock early", irq_n_w, 1'b1);
        wait_neg(1);
        chk("R6 wrap at delay", irq_n_w, 1'b0);
        cpu_write(2'd3, 8'h00);
        chk("R9 disabled hides flag", irq_n_t, 1'b1);
        cpu_write(2'd2, 8'h00);
        chk("R10 flag kept across disable", irq_n_t, 1'b0);
        chk("R10 wrap flag kept", irq_n_w, 1'b0);
        cpu_write(2'd1, 8'h00);
        chk("R10 reload clears flag", irq_n_t, 1'b1);
        chk("R10 reload clears wrap flag", irq_n_w, 1'b1);
    endtask

    // R5 R7 R11 R6
    task automatic t_span_fc();
        arm(8'hFC);
        for (int i = 0; i < 3; i++) one_line();
        chk("R5 start 252 after 3 lines", irq_n_t, 1'b1);
        one_line();
        chk("R11 start 252 fires on 4th back-to-back line", irq_n_t, 1'b0);
        wait_neg(5);
        chk("R6 wrap early", irq_n_w, 1'b1);
        wait_neg(1);
        chk("R6 wrap fires", irq_n_w, 1'b0);
        cpu_write(2'd1, 8'h00);
    endtask

    // R4
    task automatic t_top_value();
        arm(8'hFF);
        chk("R4 no fire before line", irq_n_t, 1'b1);
        one_line();
        chk("R4 start 255 fires on first line", irq_n_t, 1'b0);
        cpu_write(2'd1, 8'h00);
    endtask

    // R3
    task automatic t_a13_filter();
        arm(8'hFE);
        vid_read(1'b1, 1'b1);
        vid_read(1'b0, 1'b1);
        vid_read(1'b0, 1'b0);
        vid_read(1'b0, 1'b0);
        chk("R3 A13 high and low-low ignored", irq_n_t, 1'b1);
        one_line();
        chk("R3 first valid line", irq_n_t, 1'b1);
        one_line();
        chk("R3 second valid line fires", irq_n_t, 1'b0);
        cpu_write(2'd1, 8'h00);
    endtask

    // R2
    task automatic t_strobe_only();
        arm(8'hFE);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            vid_a12 = (i % 2 == 0);
        end
        @(negedge clk);
        vid_a12 = 1'b1; vid_rd_n = 1'b0;
        @(negedge clk);
        vid_a12 = 1'b0;
        wait_neg(2);
        vid_rd_n = 1'b1;
        wait_neg(1);
        chk("R2 A12 moves without strobe fall", irq_n_t, 1'b1);
        vid_read(1'b0, 1'b0);
        chk("R2 sampled A12 high then low counts one", irq_n_t, 1'b1);
        one_line();
        chk("R2 second event fires", irq_n_t, 1'b0);
        cpu_write(2'd1, 8'h00);
    endtask

    // R8
    task automatic t_reload_priority();
        arm(8'hFE);
        vid_read(1'b1, 1'b0);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 2'd1;
        @(negedge clk);
        cpu_wr = 1'b0; vid_a12 = 1'b0; vid_rd_n = 1'b0;
        @(negedge clk);
        vid_rd_n = 1'b1;
        chk("R8 event on reload clock dropped", irq_n_t, 1'b1);
        one_line();
        chk("R8 one line after reload", irq_n_t, 1'b1);
        one_line();
        chk("R8 second line fires", irq_n_t, 1'b0);
    endtask

    initial begin
        #(5.0 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_neg(4);
        rst = 1'b0;
        wait_neg(1);
        t_reset_and_flags();
        t_span_fc();
        t_top_value();
        t_a13_filter();
        t_strobe_only();
        t_reload_priority();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule